// File: doc/BRIEF.md
# PHY Address Discovery Scanner

This block finds the first PHY attached to a management (MDIO) bus. After a start pulse it issues read requests to an MDIO controller and walks the PHY addresses upward from zero, reading the lower identifier word at each one. A reading of all ones means the address is empty. The first address that returns anything else is the result. The scanner then reads the upper identifier word at that same address and joins the two words into a 32-bit PHY identifier.

When a whole pass over the addresses finds nothing, the scanner waits a wake-up delay and scans again, because a PHY may still be coming out of reset. The number of passes is bounded. When the last pass also comes back empty, the scanner reports that no PHY is present.

The MDIO controller sits outside this block and uses a plain level handshake. The scanner holds `mdio_req` high with a stable address and register number. The controller answers with a one-cycle `mdio_done` and puts the read data on `mdio_rdata` in that same cycle.

Top module: `phy_scan`

## Requirements
- R1: Within a pass, the lower identifier word (register number 3) is read at addresses 0, 1, 2, ... in strictly ascending order, and every pass starts at address 0.
- R2: A lower-word reading of 0xFFFF marks the address as empty. Any other value, including 0xFFFE, marks it as occupied.
- R3: After a hit, exactly one read of register number 2 is made at the hit address. `phy_id` then equals {register 2 data, register 3 data}, and `phy_addr` equals the hit address.
- R4: Scanning stops at the first occupied address. No higher address is probed, and a later occupied address never replaces the first one.
- R5: At most MAX_PASSES passes are made (11 by default). Between two passes `mdio_req` stays low for exactly WAIT_CYCLES cycles, and there is no delay before the first pass.
- R6: When every pass comes back empty, `absent` is 1, `found` is 0, and `phy_addr` and `phy_id` are 0.
- R7: A start pulse accepted while idle clears `found`, `absent`, `phy_addr` and `phy_id` by the next cycle and begins at pass 1, address 0.
- R8: A start pulse while `busy` is high has no effect: the scan continues and produces exactly one result.
- R9: `done` is high for exactly one cycle at the end of a scan. Exactly one of `found` and `absent` is set in that cycle, and both hold their values until the next accepted start.
- R10: While `mdio_req` is high and `mdio_done` is low, the address and register number stay stable. The register number is always 2 or 3.
- R11: After reset, `mdio_req`, `done`, `found`, `absent` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a scan (accepted only when idle) |
| mdio_req | output | 1 | Read request to the MDIO controller, held until done |
| mdio_phy | output | 5 | PHY address of the request |
| mdio_reg | output | 5 | Register number of the request (3 = lower ID, 2 = upper ID) |
| mdio_done | input | 1 | One-cycle completion from the controller |
| mdio_rdata | input | 16 | Read data, valid with mdio_done |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | A PHY was found (held) |
| absent | output | 1 | No PHY answered in any pass (held) |
| phy_addr | output | 5 | Address of the PHY found |
| phy_id | output | 32 | Identifier of the PHY found, upper word first |

## Verification
The bench places PHYs at address 0 and at address 31. A design with an off-by-one in the wrap or stop test would either skip these addresses or run past them. It also places two PHYs at once, so that a scanner that does not stop at the first hit returns the higher address or makes extra probes. A PHY that only appears in the third pass checks the pass counter and the exact length of the gap between passes. An empty bus must take eleven full passes and ten gaps, so an error of one in the pass limit changes the probe count. An ID word of 0xFFFE catches a presence test that compares too few bits. A start pulse in the middle of a scan must not restart it or produce a second result.

// File: rtl/phy_scan.sv
module phy_scan #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int WAIT_CYCLES = CLK_HZ / 100,
  parameter int MAX_PASSES  = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        mdio_req,
  output logic [4:0]  mdio_phy,
  output logic [4:0]  mdio_reg,
  input  logic        mdio_done,
  input  logic [15:0] mdio_rdata,
  output logic        busy,
  output logic        done,
  output logic        found,
  output logic        absent,
  output logic [4:0]  phy_addr,
  output logic [31:0] phy_id
);

  localparam int PW = $clog2(MAX_PASSES + 1);
  localparam int CW = $clog2(WAIT_CYCLES + 1);
  localparam logic [4:0] REG_HI = 5'd2;
  localparam logic [4:0] REG_LO = 5'd3;
  localparam logic [4:0] LAST_ADDR = 5'd31;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_LO, S_HI} st_t;

  st_t         st;
  logic [4:0]  addr;
  logic [PW-1:0] pass;
  logic [CW-1:0] cnt;

  assign busy     = (st != S_IDLE);
  assign mdio_req = (st == S_LO) || (st == S_HI);
  assign mdio_reg = (st == S_HI) ? REG_HI : REG_LO;
  assign mdio_phy = addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      addr     <= '0;
      pass     <= '0;
      cnt      <= '0;
      done     <= 1'b0;
      found    <= 1'b0;
      absent   <= 1'b0;
      phy_addr <= '0;
      phy_id   <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          found    <= 1'b0;
          absent   <= 1'b0;
          phy_addr <= '0;
          phy_id   <= '0;
          addr     <= '0;
          pass     <= PW'(1);
          st       <= S_LO;
        end
        S_WAIT: begin
          if (cnt == CW'(WAIT_CYCLES - 1)) begin
            cnt <= '0;
            st  <= S_LO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_LO: if (mdio_done) begin
          if (mdio_rdata != 16'hFFFF) begin
            phy_id[15:0] <= mdio_rdata;
            phy_addr     <= addr;
            st           <= S_HI;
          end else if (addr == LAST_ADDR) begin
            addr <= '0;
            if (pass == PW'(MAX_PASSES)) begin
              absent <= 1'b1;
              done   <= 1'b1;
              st     <= S_IDLE;
            end else begin
              pass <= pass + 1'b1;
              cnt  <= '0;
              st   <= S_WAIT;
            end
          end else begin
            addr <= addr + 1'b1;
          end
        end
        S_HI: if (mdio_done) begin
          phy_id[31:16] <= mdio_rdata;
          found         <= 1'b1;
          done          <= 1'b1;
          st            <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_scan_chk.sv
module phy_scan_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       mdio_req,
  input logic [4:0] mdio_phy,
  input logic [4:0] mdio_reg,
  input logic       mdio_done,
  input logic       busy,
  input logic       done,
  input logic       found,
  input logic       absent
);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (found != absent));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !$past(start)) |-> ($stable(found) && $stable(absent)));

  p_regnum_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> (mdio_reg == 5'd2 || mdio_reg == 5'd3));

  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && !mdio_done) |=> (mdio_req && $stable(mdio_phy) && $stable(mdio_reg)));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_reg == 5'd3 && $past(mdio_req && mdio_reg == 5'd3 && mdio_done)
     && $past(mdio_phy) != 5'd31) |-> (mdio_phy == 5'($past(mdio_phy) + 5'd1)));

  p_hi_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_req && mdio_reg == 5'd2) |-> (mdio_phy == $past(mdio_phy)));

  p_req_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_req |-> busy);

endmodule

bind phy_scan phy_scan_chk u_chk (.*);

// File: tb/phy_scan_bench.sv
module phy_scan_bench;
  localparam int W    = 20;
  localparam int NP   = 11;
  localparam int LAT  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mdio_req, mdio_done = 1'b0;
  logic [4:0] mdio_phy, mdio_reg;
  logic [15:0] mdio_rdata = '0;
  logic busy, done, found, absent;
  logic [4:0] phy_addr;
  logic [31:0] phy_id;

  always #5 clk = ~clk;

  phy_scan #(.CLK_HZ(2000), .WAIT_CYCLES(W), .MAX_PASSES(NP)) u_phy_scan (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mdio_req(mdio_req), .mdio_phy(mdio_phy), .mdio_reg(mdio_reg),
    .mdio_done(mdio_done), .mdio_rdata(mdio_rdata),
    .busy(busy), .done(done), .found(found), .absent(absent),
    .phy_addr(phy_addr), .phy_id(phy_id));

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // PHY population model
  logic        present [32];
  logic [15:0] id_hi   [32];
  logic [15:0] id_lo   [32];
  int appear_pass;

  // responder state
  int pass_seen, last_a, hit_a, lo_probes, hi_probes, gap;

  initial begin
    @(negedge clk);
    forever begin
      if (mdio_req) begin
        automatic int a = mdio_phy;
        automatic logic [15:0] d;
        if (gap > 0) begin
          chk("R5 gap length", gap, W);
          chk("R5 gap after last address", last_a, 31);
        end
        gap = 0;
        if (mdio_reg == 5'd3) begin
          if (a == 0) pass_seen++;
          chk("R1 ascending address", a, (last_a < 0 || last_a == 31) ? 0 : last_a + 1);
          if (hit_a >= 0) chk("R4 probe after hit", 1, 0);
          last_a = a;
          lo_probes++;
          d = (present[a] && pass_seen >= appear_pass) ? id_lo[a] : 16'hFFFF;
          if (d != 16'hFFFF) hit_a = a;
        end else begin
          chk("R3 upper read address", a, hit_a);
          hi_probes++;
          d = id_hi[a];
        end
        repeat (LAT) @(negedge clk);
        mdio_done  = 1'b1;
        mdio_rdata = d;
        @(negedge clk);
        mdio_done  = 1'b0;
        mdio_rdata = '0;
      end else begin
        if (busy) gap++;
        @(negedge clk);
      end
    end
  end

  typedef struct {
    bit          f;
    logic [4:0]  ad;
    logic [31:0] id;
    int          lo;
    int          hi;
  } exp_t;
  exp_t q[$];
  int n_done = 0;

  // monitor
  initial forever begin
    @(negedge clk);
    if (done) begin
      n_done++;
      if (q.size() == 0) chk("R8 unexpected result", 1, 0);
      else begin
        automatic exp_t e = q.pop_front();
        chk("R9 found flag", found, e.f);
        chk("R6/R9 absent flag", absent, !e.f);
        chk("R3 phy_addr", phy_addr, e.ad);
        chk("R3 phy_id", phy_id, e.id);
        chk("R4/R5 lower probe count", lo_probes, e.lo);
        chk("R3 upper probe count", hi_probes, e.hi);
        @(negedge clk);
        chk("R9 done single cycle", done, 0);
        chk("R9 result held", {found, absent}, {e.f, !e.f});
      end
    end
  end

  task automatic clear_pop();
    for (int i = 0; i < 32; i++) begin
      present[i] = 1'b0; id_hi[i] = '0; id_lo[i] = '0;
    end
    appear_pass = 1;
  endtask

  task automatic place(input int a, input logic [15:0] hi, input logic [15:0] lo);
    present[a] = 1'b1; id_hi[a] = hi; id_lo[a] = lo;
  endtask

  // driver: compute expectation, push, run, wait for result
  task automatic run_case(input bit poke_busy);
    exp_t e;
    int hit = -1, hp = 0;
    for (int p = 1; p <= NP && hit < 0; p++)
      for (int a = 0; a < 32 && hit < 0; a++)
        if (present[a] && p >= appear_pass && id_lo[a] != 16'hFFFF) begin
          hit = a; hp = p;
        end
    e.f  = (hit >= 0);
    e.ad = e.f ? 5'(hit) : 5'd0;
    e.id = e.f ? {id_hi[hit], id_lo[hit]} : 32'd0;
    e.lo = e.f ? (hp - 1) * 32 + hit + 1 : NP * 32;
    e.hi = e.f ? 1 : 0;
    pass_seen = 0; last_a = -1; hit_a = -1; lo_probes = 0; hi_probes = 0; gap = 0;
    q.push_back(e);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R7 cleared after start", {found, absent, phy_addr, phy_id}, 0);
    chk("R7 busy after start", busy, 1);
    if (poke_busy) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    clear_pop();
    repeat (3) @(negedge clk);
    chk("R11 reset outputs", {mdio_req, done, found, absent, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle after reset", {mdio_req, busy}, 0);

    clear_pop(); place(5, 16'h0022, 16'h1619);           run_case(0); // R3
    clear_pop(); place(0, 16'h0181, 16'hB881);           run_case(0); // R1 boundary low
    clear_pop(); place(31, 16'hFFFF, 16'h1234);          run_case(0); // R1 boundary high
    clear_pop(); place(7, 16'hAAAA, 16'h5555);
                 place(12, 16'h1111, 16'h2222);          run_case(0); // R4
    clear_pop(); place(9, 16'h0013, 16'hFFFE);           run_case(0); // R2
    clear_pop(); place(20, 16'h0016, 16'hF870);
                 appear_pass = 3;                        run_case(0); // R5
    clear_pop();                                         run_case(0); // R6
    clear_pop(); place(18, 16'h00AB, 16'hCDEF);          run_case(1); // R8
    chk("R8 single result", n_done, 8);
    summary();
  end
endmodule